// File: doc/BRIEF.md
# Frame line-count interrupt generator

This block watches the horizontal and vertical sync strobes of an image sensor stream and counts lines within each frame. A frame begins on the active edge of the vertical strobe. That edge clears a line counter. Each later active edge of the horizontal strobe adds one to the counter. Two 15-bit thresholds, held in one 32-bit configuration word, each drive a separate one-clock interrupt pulse. A pulse fires on the line whose number is the threshold plus one. A threshold of zero therefore fires on the first counted line.

The active edge of each strobe can be set to rising or falling on its own. A horizontal edge that arrives in the same clock as the vertical edge belongs to the frame boundary and is not counted. The counter stops at its maximum value, so a frame with no closing vertical edge cannot produce a second pulse. Thresholds written through the configuration port are held back and only reach the comparators at the next frame start. A frame already in progress keeps comparing against one consistent pair.

Top module: `line_irq_gen`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `line_count` is 0 and both interrupts are low. No strobe edge is recognised in the first clock after reset, and no line is counted before the first frame start.
- R2: An active vertical edge sets `line_count` to 0 on the next clock and starts a frame. After that, each active horizontal edge adds one to `line_count` on the next clock.
- R3: `hsync_fall` and `vsync_fall` each choose the active edge of their strobe: 0 selects rising and 1 selects falling. The two selects are independent.
- R4: `irq_a` pulses for one clock on the clock in which `line_count` becomes threshold A + 1. Threshold A is configuration bits 30:16. `irq_b` does the same for threshold B, which is configuration bits 14:0.
- R5: A horizontal edge that falls in the same clock as a vertical edge is not counted, and it does not raise an interrupt.
- R6: `line_count` saturates at 16'hFFFF and does not wrap.
- R7: Configuration bits 31 and 15 are ignored on write and read as 0. `cfg_rdata` returns the last written thresholds.
- R8: A write reaches the comparators at the next frame start. A write in the same clock as a frame start is used from the frame after that.
- R9: Each interrupt pulses at most once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync strobe, synchronous to clk |
| vsync_in | input | 1 | Vertical sync strobe, synchronous to clk |
| hsync_fall | input | 1 | 1 selects the falling edge of hsync_in as active |
| vsync_fall | input | 1 | 1 selects the falling edge of vsync_in as active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data: A in 30:16, B in 14:0 |
| cfg_rdata | output | 32 | Configuration read data |
| irq_a | output | 1 | Threshold A interrupt pulse |
| irq_b | output | 1 | Threshold B interrupt pulse |
| line_count | output | 16 | Current line count, for debug |

## Verification
The assertions assume the strobes are already synchronous to `clk`. They also assume the polarity selects change only while both strobes sit at their inactive level, so a change of select never looks like an edge. The stimulus holds every strobe level for at least one whole clock. It flips a polarity only between frames, after it has put the strobe at the new idle level. The one exception is the deliberate case where a strobe is held active through reset. That case is used to show that edges are suppressed in the first clock after reset.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

    localparam int THR_W  = 15;
    localparam int CNT_W  = THR_W + 1;
    localparam int REG_W  = 32;
    localparam int A_LSB  = 16;
    localparam int B_LSB  = 0;
    localparam int N_IRQ  = 2;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        thr_t a;
        thr_t b;
    } thr_pair_t;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_ev_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    function automatic thr_pair_t cfg_unpack(input logic [REG_W-1:0] w);
        thr_pair_t p;
        p.a = w[A_LSB +: THR_W];
        p.b = w[B_LSB +: THR_W];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input thr_pair_t p);
        logic [REG_W-1:0] w;
        w = '0;
        w[A_LSB +: THR_W] = p.a;
        w[B_LSB +: THR_W] = p.b;
        return w;
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det
    import line_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    input  edge_pol_e pol,
    output logic      edge_o
);
    logic prev_q;
    logic armed_q;
    logic lvl_now;
    logic lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= sig_in;
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        lvl_now  = sig_in ^ (pol == EDGE_FALL);
        lvl_prev = prev_q ^ (pol == EDGE_FALL);
        edge_o   = armed_q & lvl_now & ~lvl_prev;
    end
endmodule

// File: rtl/line_counter.sv
module line_counter
    import line_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sync_ev_t ev,
    output cnt_t     count_o,
    output logic     step_o
);
    cnt_t count_q;
    logic in_frame_q;

    always_comb begin
        step_o = in_frame_q & ev.hs & ~ev.vs & (count_q != CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q    <= '0;
            in_frame_q <= 1'b0;
        end else if (ev.vs) begin
            count_q    <= '0;
            in_frame_q <= 1'b1;
        end else if (step_o) begin
            count_q    <= count_q + cnt_t'(1);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/thresh_regs.sv
module thresh_regs
    import line_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             frame_start,
    output logic [REG_W-1:0] rdata,
    output thr_pair_t        active_o
);
    thr_pair_t pend_q;
    thr_pair_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (frame_start) begin
                act_q <= pend_q;
            end
            if (we) begin
                pend_q <= cfg_unpack(wdata);
            end
        end
    end

    assign rdata    = cfg_pack(pend_q);
    assign active_o = act_q;
endmodule

// File: rtl/line_match.sv
module line_match
    import line_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  cnt_t count,
    input  thr_t thr,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= step & (count == cnt_t'(thr));
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/line_irq_gen.sv
module line_irq_gen
    import line_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync_in,
    input  logic        vsync_in,
    input  logic        hsync_fall,
    input  logic        vsync_fall,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq_a,
    output logic        irq_b,
    output logic [15:0] line_count
);
    sync_ev_t  ev;
    logic      hs_edge;
    logic      vs_edge;
    logic      step;
    cnt_t      count;
    thr_pair_t thr_act;
    thr_t      thr_vec [N_IRQ];
    logic      irq_vec [N_IRQ];
    thr_t      thr_act_a;
    thr_t      thr_act_b;

    sync_edge_det u_hs_det (
        .clk    (clk),
        .rst    (rst),
        .sig_in (hsync_in),
        .pol    (edge_pol_e'(hsync_fall)),
        .edge_o (hs_edge)
    );

    sync_edge_det u_vs_det (
        .clk    (clk),
        .rst    (rst),
        .sig_in (vsync_in),
        .pol    (edge_pol_e'(vsync_fall)),
        .edge_o (vs_edge)
    );

    assign ev.hs = hs_edge;
    assign ev.vs = vs_edge;

    line_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .count_o (count),
        .step_o  (step)
    );

    thresh_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .frame_start (vs_edge),
        .rdata       (cfg_rdata),
        .active_o    (thr_act)
    );

    assign thr_act_a  = thr_act.a;
    assign thr_act_b  = thr_act.b;
    assign thr_vec[0] = thr_act_a;
    assign thr_vec[1] = thr_act_b;

    for (genvar ch = 0; ch < N_IRQ; ch++) begin : g_ch
        line_match u_match (
            .clk   (clk),
            .rst   (rst),
            .step  (step),
            .count (count),
            .thr   (thr_vec[ch]),
            .irq_o (irq_vec[ch])
        );
    end

    assign irq_a      = irq_vec[0];
    assign irq_b      = irq_vec[1];
    assign line_count = count;
endmodule

// File: rtl/line_irq_checker.sv
module line_irq_checker
    import line_irq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        hs_edge,
    input logic        vs_edge,
    input logic [15:0] line_count,
    input logic        irq_a,
    input logic        irq_b,
    input logic [31:0] cfg_rdata,
    input thr_t        thr_a,
    input thr_t        thr_b
);
    logic seen_a_q;
    logic seen_b_q;

    always_ff @(posedge clk) begin
        if (rst || vs_edge) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else begin
            if (irq_a) seen_a_q <= 1'b1;
            if (irq_b) seen_b_q <= 1'b1;
        end
    end

    p_frame_clear_r2: assert property (@(posedge clk) disable iff (rst)
        vs_edge |=> (line_count == 16'd0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        !vs_edge |=> (line_count == $past(line_count) ||
                      line_count == 16'($past(line_count) + 16'd1)));

    p_coincide_r5: assert property (@(posedge clk) disable iff (rst)
        (vs_edge && hs_edge) |=> (!irq_a && !irq_b));

    p_irq_a_line_r4: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> (line_count == 16'({1'b0, thr_a}) + 16'd1));

    p_irq_b_line_r4: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> (line_count == 16'({1'b0, thr_b}) + 16'd1));

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        irq_a |=> !irq_a);

    p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
        (line_count == 16'hFFFF && !vs_edge) |=> (line_count == 16'hFFFF));

    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[31] == 1'b0 && cfg_rdata[15] == 1'b0));

    p_once_a_r9: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> !seen_a_q);

    p_once_b_r9: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> !seen_b_q);
endmodule

bind line_irq_gen line_irq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .hs_edge    (hs_edge),
    .vs_edge    (vs_edge),
    .line_count (line_count),
    .irq_a      (irq_a),
    .irq_b      (irq_b),
    .cfg_rdata  (cfg_rdata),
    .thr_a      (thr_act_a),
    .thr_b      (thr_act_b)
);

// File: tb/test_line_irq_gen.sv
module test_line_irq_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_in = 1'b0;
    logic        vsync_in = 1'b0;
    logic        hsync_fall = 1'b0;
    logic        vsync_fall = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_a;
    logic        irq_b;
    logic [15:0] line_count;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int irq_a_n = 0, irq_b_n = 0;
    int irq_a_line = -1, irq_b_line = -1;

    // behavioural reference state
    int m_cnt = 0;
    int m_pend = 0;
    int m_thr_a = 0, m_thr_b = 0;
    bit m_frame = 0, m_armed = 0, m_hs_prev = 0, m_vs_prev = 0;
    bit e_irq_a = 0, e_irq_b = 0;

    always #5 clk = ~clk;

    line_irq_gen i_line_irq_gen (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .hsync_fall(hsync_fall), .vsync_fall(vsync_fall),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_a(irq_a), .irq_b(irq_b), .line_count(line_count)
    );

    always @(posedge clk) begin
        bit eh, ev;
        eh = m_armed && ((hsync_in ^ hsync_fall) == 1'b1) && ((m_hs_prev ^ hsync_fall) == 1'b0);
        ev = m_armed && ((vsync_in ^ vsync_fall) == 1'b1) && ((m_vs_prev ^ vsync_fall) == 1'b0);
        e_irq_a = 0;
        e_irq_b = 0;
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_thr_a = 0; m_thr_b = 0;
            m_frame = 0; m_armed = 0; m_hs_prev = 0; m_vs_prev = 0;
        end else begin
            if (ev) begin
                m_frame = 1; m_cnt = 0;
                m_thr_a = (m_pend >> 16) & 32'h7FFF;
                m_thr_b = m_pend & 32'h7FFF;
            end else if (m_frame && eh && m_cnt < 65535) begin
                m_cnt = m_cnt + 1;
                e_irq_a = (m_cnt == m_thr_a + 1);
                e_irq_b = (m_cnt == m_thr_b + 1);
            end
            if (cfg_we) m_pend = cfg_wdata & 32'h7FFF7FFF;
            m_hs_prev = hsync_in; m_vs_prev = vsync_in; m_armed = 1;
        end
    end

    always @(negedge clk) begin
        cyc++;
        n_vec++;
        if (line_count !== 16'(m_cnt)) begin
            n_bad++;
            $display("FAIL R2 line_count act=%0d exp=%0d cyc=%0d", line_count, m_cnt, cyc);
        end
        if (irq_a !== e_irq_a || irq_b !== e_irq_b) begin
            n_bad++;
            $display("FAIL R4 irq act=%b%b exp=%b%b cyc=%0d", irq_a, irq_b, e_irq_a, e_irq_b, cyc);
        end
        if (cfg_rdata !== 32'(m_pend)) begin
            n_bad++;
            $display("FAIL R7 cfg_rdata act=%h exp=%h", cfg_rdata, m_pend);
        end
        if (irq_a) begin irq_a_n++; irq_a_line = line_count; end
        if (irq_b) begin irq_b_n++; irq_b_line = line_count; end
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp<=190000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_irq();
        irq_a_n = 0; irq_b_n = 0; irq_a_line = -1; irq_b_line = -1;
    endtask

    task automatic hs_line();
        hsync_in = ~hsync_fall; tick(1);
        hsync_in = hsync_fall;  tick(1);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) hs_line();
    endtask

    task automatic frame_start();
        vsync_in = ~vsync_fall; tick(2);
        vsync_in = vsync_fall;  tick(1);
    endtask

    task automatic cfg_write(input logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d; tick(1);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        // R1: vsync held active through reset must not start a frame
        vsync_in = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 rdata", int'(cfg_rdata), 0);
        check("R1 irq", int'(irq_a | irq_b), 0);
        lines(3);
        check("R1 no count before frame", int'(line_count), 0);
        vsync_in = 1'b0; tick(2);

        // R7: reserved bits dropped
        cfg_write(32'hFFFF_FFFF);
        check("R7 rsvd read", int'(cfg_rdata), 32'h7FFF7FFF);
        cfg_write({1'b1, 15'd2, 1'b1, 15'd4});
        check("R7 readback", int'(cfg_rdata), {1'b0, 15'd2, 1'b0, 15'd4});

        // R2 R4: thresholds A=2 B=4
        frame_start(); clr_irq();
        check("R2 cleared", int'(line_count), 0);
        lines(6);
        check("R2 count", int'(line_count), 6);
        check("R4 irq_a line", irq_a_line, 3);
        check("R4 irq_b line", irq_b_line, 5);
        lines(4);
        check("R9 irq_a once", irq_a_n, 1);
        check("R9 irq_b once", irq_b_n, 1);

        // R8: mid-frame write applies from next frame
        cfg_write({1'b0, 15'd0, 1'b0, 15'd1});
        frame_start(); clr_irq();
        lines(5);
        check("R8 zero thr fires on line 1", irq_a_line, 1);
        check("R8 B thr 1", irq_b_line, 2);
        // write coincident with frame start
        vsync_in = 1'b1; cfg_we = 1'b1; cfg_wdata = {1'b0, 15'd6, 1'b0, 15'd6}; tick(1);
        cfg_we = 1'b0; tick(1); vsync_in = 1'b0; tick(1);
        clr_irq();
        lines(3);
        check("R8 same-cycle write not yet used", irq_a_line, 1);
        frame_start(); clr_irq();
        lines(8);
        check("R8 same-cycle write next frame", irq_a_line, 7);

        // R5: HS edge coincident with VS edge excluded
        cfg_write({1'b0, 15'd0, 1'b0, 15'd2});
        frame_start();
        hsync_in = 1'b1; vsync_in = 1'b1; tick(1);
        hsync_in = 1'b0; tick(1); vsync_in = 1'b0; clr_irq();
        lines(2);
        check("R5 coincident hs not counted", int'(line_count), 2);
        check("R5 irq_a at first real line", irq_a_line, 1);

        // R3: falling polarity on both strobes
        hsync_fall = 1'b1; hsync_in = 1'b1;
        vsync_fall = 1'b1; vsync_in = 1'b1; tick(2);
        frame_start(); clr_irq();
        check("R3 falling vs clears", int'(line_count), 0);
        lines(4);
        check("R3 falling hs count", int'(line_count), 4);
        check("R3 falling irq_b", irq_b_line, 3);
        // mixed: hs rising, vs falling
        hsync_fall = 1'b0; hsync_in = 1'b0; tick(2);
        frame_start(); lines(3);
        check("R3 mixed polarity", int'(line_count), 3);
        vsync_fall = 1'b0; vsync_in = 1'b0; tick(2);

        // R6: saturation, max threshold on B
        cfg_write({1'b0, 15'd0, 1'b0, 15'h7FFF});
        frame_start(); clr_irq();
        lines(65540);
        check("R6 saturated", int'(line_count), 65535);
        check("R4 max thr B line", irq_b_line, 32768);
        check("R9 irq_b once at saturation", irq_b_n, 1);
        frame_start();
        check("R2 clear after saturation", int'(line_count), 0);

        tick(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule